// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a watchdog peripheral on a plain 32-bit register bus. Software loads a period selection, turns the watchdog on, and must then keep writing a fixed key value to a restart register. Each write reloads a down-counter. If the counter runs out, the block responds in one of two ways, chosen by a control bit. In reset mode it asserts a reset request at once. In interrupt mode it first raises an interrupt and reloads the counter. A reset request follows only if the reloaded period also runs out while that interrupt is still pending.

Period selection uses two 4-bit selectors. One gives the count for the very first period after enabling. The other gives every later period. A selector value `n` gives a reload of `2^(PERIOD_LOG2_MIN+n) - 1` cycles, so the default range runs from `2^16-1` up to `2^31-1` cycles. A build option fixes the selectors at their reset value. A capability register reports whether this option is set. The reset request is a pulse of fixed length. After the pulse the counter stays halted until the block is reset.

Top module: `wdog_twostage`

## Requirements
- R1: After reset, control (0x00) reads 0, period-select (0x04) reads the `RESET_TRANGE` value, count (0x08) reads 0, the pending bit at 0x10 reads 0, and both `wdt_irq` and `wdt_rst_req` are low.
- R2: Control bit 0 is the enable and control bit 1 is the response mode (1 = interrupt first). Writing 1 to the enable sets it, and only a reset clears it. The mode bit always takes the written value.
- R3: Setting the enable loads the counter with `2^(PERIOD_LOG2_MIN+s)-1`, where `s` is period-select bits [7:4] (the initial selector). The counter then counts down by one per cycle. The first response becomes visible `reload+1` cycles after the enabling write.
- R4: In reset mode an expiry drives `wdt_rst_req` high for exactly `RST_PULSE_CYCLES` cycles and never raises `wdt_irq`. The counter then stays at 0, and later restarts have no effect.
- R5: In interrupt mode the first expiry raises `wdt_irq` and reloads the counter from the normal selector (period-select bits [3:0]). An expiry while the interrupt is still pending starts the reset pulse.
- R6: Writing exactly 0x00000076 to 0x0c while running reloads the counter from the normal selector and clears the pending interrupt. Any other value, or any write while disabled, has no effect.
- R7: Reading 0x10 returns the pending flag in bit 0 and has no side effect. Reading 0x14 returns the same flag and clears it. After such a clear, the next expiry is treated as a first stage again.
- R8: The normal selector is captured at enable and at each restart. A new value written to 0x04 while running changes the reload only from the next restart on.
- R9: Register 0xf4 bit 6 reports the fixed-selection option. Without it, 0x04 reads back bits [7:0] as last written. With it, writes to 0x04 are ignored and it keeps `RESET_TRANGE`.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. Unmapped and write-only addresses (including 0x0c) read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_wr | input | 1 | Write qualifier |
| bus_rd | input | 1 | Read qualifier |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wdt_irq | output | 1 | Level interrupt for the first-stage expiry |
| wdt_rst_req | output | 1 | Reset request pulse |

## Verification
The bench measures, to the cycle, the delay from the enabling write or restart to each response. A counter that is off by one, or that reloads from the initial selector instead of the normal one, shows up as a wrong delay. It checks that a selector change made without a restart does not alter the second-stage period, so a design that reads the live register field fails. It sends near-miss key values and a restart after the reset pulse, and expects no effect from either. It checks that a clear-by-read turns the next expiry back into an interrupt rather than a reset. A design that tracks the stages with its own flag instead of the pending interrupt would request a reset there.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SEL_W  = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h00;
  localparam logic [ADDR_W-1:0] A_TRANGE = 8'h04;
  localparam logic [ADDR_W-1:0] A_COUNT  = 8'h08;
  localparam logic [ADDR_W-1:0] A_KICK   = 8'h0c;
  localparam logic [ADDR_W-1:0] A_STAT   = 8'h10;
  localparam logic [ADDR_W-1:0] A_CLR    = 8'h14;
  localparam logic [ADDR_W-1:0] A_PARAM  = 8'hf4;

  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_0076;
  localparam int PARAM_FIXED_BIT = 6;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } wdog_state_e;
endpackage

// File: rtl/wdog_reload.sv
// Turns a period selector into an all-ones reload value of the matching length.
module wdog_reload #(
  parameter int BASE  = 16,
  parameter int SEL_W = 4,
  parameter int CW    = 31
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [CW-1:0]    value_o
);
  localparam logic [SEL_W-1:0] MAX_SEL = '1;
  localparam logic [CW-1:0]    ONES    = '1;

  logic [SEL_W-1:0] shamt;

  // largest selector keeps every bit; each step down drops one top bit
  assign shamt   = MAX_SEL - sel_i;
  assign value_o = ONES >> shamt;
endmodule

// File: rtl/wdog_pulse.sv
// Fixed-length reset request pulse, started by a single-cycle fire strobe.
module wdog_pulse #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  localparam int PW = $clog2(LEN + 1);

  logic [PW-1:0] left_q;
  logic          q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= 1'b0;
      left_q <= '0;
    end else if (fire_i) begin
      q      <= 1'b1;
      left_q <= PW'(LEN - 1);
    end else if (left_q != '0) begin
      left_q <= left_q - 1'b1;
    end else begin
      q <= 1'b0;
    end
  end

  assign pulse_o = q;

  // R4: the pulse may not drop while cycles remain
  p_pulse_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (q && left_q != '0) |=> q);
endmodule

// File: rtl/wdog_core.sv
// Down-counter with the two-stage expiry sequencing.
module wdog_core
  import wdog_pkg::*;
#(
  parameter int BASE  = 16,
  parameter int SEL_W = 4,
  parameter int CW    = 31
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             kick_i,
  input  logic             clr_i,
  input  logic             mode_i,
  input  logic [SEL_W-1:0] sel_norm_i,
  input  logic [SEL_W-1:0] sel_init_i,
  output logic [CW-1:0]    cnt_o,
  output logic             irq_o,
  output logic             fire_o
);
  localparam int NSRC  = 3;
  localparam int S_INI = 0;
  localparam int S_NRM = 1;
  localparam int S_ACT = 2;

  wdog_state_e      state_q;
  logic [CW-1:0]    cnt_q;
  logic             irq_q;
  logic [SEL_W-1:0] sel_act_q;

  logic [SEL_W-1:0] sel_src [NSRC];
  logic [CW-1:0]    reload  [NSRC];

  assign sel_src[S_INI] = sel_init_i;
  assign sel_src[S_NRM] = sel_norm_i;
  assign sel_src[S_ACT] = sel_act_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_rld
    wdog_reload #(.BASE(BASE), .SEL_W(SEL_W), .CW(CW)) u_rld (
      .sel_i   (sel_src[g]),
      .value_o (reload[g])
    );
  end

  logic running, at_zero, expire, first_stage;

  assign running     = (state_q == ST_RUN);
  assign at_zero     = (cnt_q == '0);
  assign expire      = running && !kick_i && at_zero;
  assign first_stage = expire && mode_i && !irq_q;
  assign fire_o      = expire && !first_stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      sel_act_q <= '0;
    end else begin
      if (clr_i) irq_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q     <= reload[S_INI];
            sel_act_q <= sel_norm_i;
            state_q   <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (kick_i) begin
            cnt_q     <= reload[S_NRM];
            sel_act_q <= sel_norm_i;
            irq_q     <= 1'b0;
          end else if (!at_zero) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (first_stage) begin
            irq_q <= 1'b1;
            cnt_q <= reload[S_ACT];
          end else begin
            state_q <= ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  // R5: an interrupt only rises while interrupt-first mode is selected
  p_irq_needs_mode_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(mode_i));

  // R6: a restart while running leaves nothing pending
  p_kick_clears_irq_r6: assert property (@(posedge clk) disable iff (rst)
    (kick_i && running) |=> !irq_q);

  // R7: a clearing read away from an expiry leaves nothing pending
  p_clear_read_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_i && running && !at_zero) |=> !irq_q);

  // R4: once the reset request is issued the counter is frozen
  p_halt_after_fire_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DONE) |=> ($stable(cnt_q) && state_q == ST_DONE));
endmodule

// File: rtl/wdog_regs.sv
// Register decode, storage and registered read port.
module wdog_regs
  import wdog_pkg::*;
#(
  parameter bit              FIXED_PERIODS = 1'b0,
  parameter logic [2*SEL_W-1:0] RESET_TRANGE = '0,
  parameter int              CW            = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CW-1:0]     cnt_i,
  input  logic              irq_i,
  output logic              mode_o,
  output logic [SEL_W-1:0]  sel_norm_o,
  output logic [SEL_W-1:0]  sel_init_o,
  output logic              start_o,
  output logic              kick_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] bus_rdata
);
  logic               wr_go, rd_go;
  logic               en_q, mode_q;
  logic [2*SEL_W-1:0] trange;
  logic [DATA_W-1:0]  rdata_q;
  logic [DATA_W-1:0]  rd_mux;

  assign wr_go = bus_sel && bus_wr;
  assign rd_go = bus_sel && bus_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
    end else if (wr_go && bus_addr == A_CTRL) begin
      en_q   <= en_q | bus_wdata[0];
      mode_q <= bus_wdata[1];
    end
  end

  if (FIXED_PERIODS) begin : g_fixed
    assign trange = RESET_TRANGE;
  end else begin : g_prog
    always_ff @(posedge clk) begin
      if (rst)                                trange <= RESET_TRANGE;
      else if (wr_go && bus_addr == A_TRANGE) trange <= bus_wdata[2*SEL_W-1:0];
    end
  end

  assign start_o    = wr_go && bus_addr == A_CTRL && bus_wdata[0] && !en_q;
  assign kick_o     = wr_go && bus_addr == A_KICK && bus_wdata == KICK_KEY;
  assign clr_o      = rd_go && bus_addr == A_CLR;
  assign mode_o     = mode_q;
  assign sel_norm_o = trange[SEL_W-1:0];
  assign sel_init_o = trange[2*SEL_W-1:SEL_W];

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_CTRL:   rd_mux = {{(DATA_W-2){1'b0}}, mode_q, en_q};
      A_TRANGE: rd_mux = DATA_W'(trange);
      A_COUNT:  rd_mux = DATA_W'(cnt_i);
      A_STAT:   rd_mux = {{(DATA_W-1){1'b0}}, irq_i};
      A_CLR:    rd_mux = {{(DATA_W-1){1'b0}}, irq_i};
      A_PARAM:  rd_mux[PARAM_FIXED_BIT] = FIXED_PERIODS;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_go) rdata_q <= rd_mux;
  end

  assign bus_rdata = rdata_q;

  // R2: the enable is sticky until reset
  p_enable_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    en_q |=> en_q);

  // R10: read data changes only in answer to a read strobe
  p_rdata_on_read_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(rdata_q));
endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage
  import wdog_pkg::*;
#(
  parameter int   PERIOD_LOG2_MIN  = 16,
  parameter int   RST_PULSE_CYCLES = 8,
  parameter bit   FIXED_PERIODS    = 1'b0,
  parameter logic [7:0] RESET_TRANGE = 8'h00
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdt_irq,
  output logic        wdt_rst_req
);
  localparam int CW = PERIOD_LOG2_MIN + (1 << SEL_W) - 1;

  logic             mode, start, kick, clr, irq, fire;
  logic [SEL_W-1:0] sel_norm, sel_init;
  logic [CW-1:0]    cnt;

  wdog_regs #(
    .FIXED_PERIODS (FIXED_PERIODS),
    .RESET_TRANGE  (RESET_TRANGE),
    .CW            (CW)
  ) u_regs (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .cnt_i      (cnt),
    .irq_i      (irq),
    .mode_o     (mode),
    .sel_norm_o (sel_norm),
    .sel_init_o (sel_init),
    .start_o    (start),
    .kick_o     (kick),
    .clr_o      (clr),
    .bus_rdata  (bus_rdata)
  );

  wdog_core #(
    .BASE  (PERIOD_LOG2_MIN),
    .SEL_W (SEL_W),
    .CW    (CW)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .kick_i     (kick),
    .clr_i      (clr),
    .mode_i     (mode),
    .sel_norm_i (sel_norm),
    .sel_init_i (sel_init),
    .cnt_o      (cnt),
    .irq_o      (irq),
    .fire_o     (fire)
  );

  wdog_pulse #(.LEN(RST_PULSE_CYCLES)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (fire),
    .pulse_o (wdt_rst_req)
  );

  assign wdt_irq = irq;

  // R4: no interrupt ever rises in reset mode
  p_no_irq_reset_mode_r4: assert property (@(posedge clk) disable iff (rst)
    (!mode && !irq) |=> !irq);
endmodule

// File: tb/tb_wdog_twostage.sv
module tb_wdog_twostage;
  localparam int B     = 4;
  localparam int PULSE = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata_fx;
  logic        irq, srst, irq_fx, srst_fx;

  always #5 clk = ~clk;

  wdog_twostage #(.PERIOD_LOG2_MIN(B), .RST_PULSE_CYCLES(PULSE)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .wdt_irq(irq), .wdt_rst_req(srst));

  wdog_twostage #(.PERIOD_LOG2_MIN(B), .RST_PULSE_CYCLES(PULSE),
                  .FIXED_PERIODS(1'b1), .RESET_TRANGE(8'h21)) dut_fx (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_fx),
    .wdt_irq(irq_fx), .wdt_rst_req(srst_fx));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, t_mark = 0;
  logic [31:0] rd_v, rd_fx;
  logic rst_seen = 0, irq_seen = 0;
  always @(negedge clk) begin
    if (srst) rst_seen = 1'b1;
    if (irq)  irq_seen = 1'b1;
  end

  // vector: {read, addr[7:0], data or expected[31:0]}
  localparam int NV = 18;
  localparam logic [40:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'h0}, {1'b1, 8'h04, 32'h0}, {1'b1, 8'h08, 32'h0},
    {1'b1, 8'h10, 32'h0}, {1'b1, 8'h14, 32'h0}, {1'b1, 8'hf4, 32'h0},
    {1'b0, 8'h04, 32'ha3}, {1'b1, 8'h04, 32'ha3},
    {1'b0, 8'h04, 32'hffffff5c}, {1'b1, 8'h04, 32'h5c},
    {1'b1, 8'h20, 32'h0}, {1'b1, 8'h0c, 32'h0},
    {1'b0, 8'h0c, 32'h76}, {1'b1, 8'h08, 32'h0},
    {1'b0, 8'h00, 32'h2}, {1'b1, 8'h00, 32'h2},
    {1'b0, 8'h00, 32'h0}, {1'b1, 8'h00, 32'h0}};
  localparam int VREQ [NV] = '{1, 1, 1, 1, 1, 9, 9, 9, 9, 9, 10, 10, 6, 6, 2, 2, 2, 2};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // every task starts and ends at a falling edge
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    t_mark = cyc;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_sel = 1; bus_rd = 1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 0; bus_rd = 0;
    rd_v = rdata; rd_fx = rdata_fx;
  endtask

  task automatic wait_hi(input bit use_rst, input int maxc, output int at);
    at = -1;
    for (int i = 0; i < maxc; i++) begin
      if ((use_rst ? srst : irq) === 1'b1) begin
        at = cyc;
        return;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulse_width(output int w);
    w = 0;
    while (srst === 1'b1 && w < 100) begin
      w++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int at, ti, tk, t0, w;
    @(negedge clk);
    do_reset();
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rst_req", 32'(srst), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][40]) begin
        rd(VEC[i][39:32]);
        chk($sformatf("R%0d vec%0d", VREQ[i], i), rd_v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][39:32], VEC[i][31:0]);
      end
    end
    // R9: fixed build ignores the writes above and reports the option
    rd(8'h04); chk("R9 fixed trange", rd_fx, 32'h21);
    rd(8'hf4); chk("R9 fixed param", rd_fx, 32'h40);

    // R3/R4: reset mode, initial selector 1 -> 31, normal 0 -> 15
    do_reset();
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h1); t0 = t_mark;
    rd(8'h08); chk("R3 initial load", rd_v, 31);
    irq_seen = 0;
    wait_hi(1, 200, at); chk("R3 first expiry delay", at - t0, 32);
    pulse_width(w); chk("R4 pulse width", w, PULSE);
    chk("R4 no irq in reset mode", 32'(irq_seen), 0);
    rd(8'h08); chk("R4 counter halted", rd_v, 0);
    wr(8'h0c, 32'h76);
    rd(8'h08); chk("R4 restart after fire ignored", rd_v, 0);
    rst_seen = 0;
    repeat (40) @(negedge clk);
    chk("R4 no second pulse", 32'(rst_seen), 0);
    wr(8'h00, 32'h0);
    rd(8'h00); chk("R2 enable sticky", rd_v, 32'h1);

    // R5/R7: interrupt mode, two stages
    do_reset();
    wr(8'h04, 32'h10);
    wr(8'h00, 32'h3); t0 = t_mark;
    wait_hi(0, 200, at); chk("R5 irq delay", at - t0, 32); ti = at;
    rd(8'h10); chk("R7 status read", rd_v, 1);
    chk("R7 status no side effect", 32'(irq), 1);
    wait_hi(1, 200, at); chk("R5 second stage delay", at - ti, 16);
    pulse_width(w); chk("R5 pulse width", w, PULSE);

    // R6/R8: key filtering, reload, selector captured at restart
    do_reset();
    wr(8'h04, 32'h00);
    wr(8'h00, 32'h3); t0 = t_mark;
    wait_hi(0, 200, at); chk("R3 selector 0 delay", at - t0, 16);
    wr(8'h0c, 32'h55);  chk("R6 wrong key ignored", 32'(irq), 1);
    wr(8'h0c, 32'h176); chk("R6 near key ignored", 32'(irq), 1);
    wr(8'h0c, 32'h76);  tk = t_mark;
    chk("R6 restart clears irq", 32'(irq), 0);
    rd(8'h08); chk("R6 reload normal period", rd_v, 15);
    wr(8'h04, 32'h01);
    wait_hi(0, 200, at); chk("R8 period after restart", at - tk, 16); ti = at;
    wait_hi(1, 200, at); chk("R8 new selector not yet used", at - ti, 16);

    do_reset();
    wr(8'h04, 32'h00);
    wr(8'h00, 32'h3);
    wr(8'h04, 32'h01);
    wr(8'h0c, 32'h76);
    rd(8'h08); chk("R8 new selector at restart", rd_v, 31);

    // R7: clear by read makes the next expiry a first stage again
    do_reset();
    wr(8'h04, 32'h00);
    wr(8'h00, 32'h3);
    wait_hi(0, 200, at); ti = at;
    rd(8'h14); chk("R7 clear read value", rd_v, 1);
    chk("R7 clear read drops irq", 32'(irq), 0);
    rd(8'h10); chk("R7 status after clear", rd_v, 0);
    rst_seen = 0;
    wait_hi(0, 200, at); chk("R7 irq again", at - ti, 16);
    chk("R7 no reset after clear", 32'(rst_seen | srst), 0);

    // R6: periodic restarts keep reset mode alive
    do_reset();
    wr(8'h04, 32'h00);
    wr(8'h00, 32'h1);
    rst_seen = 0;
    for (int k = 0; k < 6; k++) begin
      repeat (8) @(negedge clk);
      wr(8'h0c, 32'h76);
    end
    tk = t_mark;
    chk("R6 keepalive no reset", 32'(rst_seen), 0);
    wait_hi(1, 200, at); chk("R6 expiry after last restart", at - tk, 16);

    summary();
    $finish;
  end
endmodule